// File: doc/BRIEF.md
# Highway and Farm-Road Intersection Light Controller

This block sequences the lamps at a junction where a busy highway meets a lightly used farm road. The highway is green by default. A farm-road vehicle sensor can claim the junction, but only after the highway has had a full long green interval. Once the farm road is green, it stays green while vehicles keep arriving, and never longer than the long interval. Each yellow phase lasts one short interval.

A built-in interval timer provides a short-expiry flag and a long-expiry flag. Both lengths are parameters. The controller restarts the timer with a one-cycle strobe on every state change. Next state and strobe come from a lookup table. The table is indexed by an initialisation bit, the synchronised sensor, the two timer flags and the present state. The lamps depend on the present state only. The sensor input may be asynchronous, because it is synchronised inside the block.

Top module: `hwy_farm_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the lamps show highway green with farm red and tmr_start_o is 1. The block then stays in highway green and starts the timer.
- R2: Each road has exactly one lamp lit. The four phases show the following pairs: highway green/farm red, highway yellow/farm red, farm green/highway red and farm yellow/highway red.
- R3: The block leaves highway green only in a cycle where the long interval has expired and the synchronised sensor reads 1. It then enters highway yellow.
- R4: The block moves from highway yellow to farm green in the cycle in which the short interval has expired.
- R5: The block moves from farm green to farm yellow when the long interval has expired or the synchronised sensor reads 0, whichever comes first.
- R6: The block moves from farm yellow to highway green in the cycle in which the short interval has expired.
- R7: tmr_start_o is 1 exactly in the cycles in which the state changes on the next edge, and in the initialisation cycle.
- R8: The short flag is set SHORT_CNT edges after a strobe. The long flag is set LONG_CNT edges after a strobe. Both flags remain set until the next strobe.
- R9: car_i passes through two flops before the controller uses it. A change on car_i therefore first steers a decision in the cycle that follows the second clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_i | input | 1 | Farm-road vehicle sensor (asynchronous) |
| hwy_grn_o | output | 1 | Highway green lamp |
| hwy_yel_o | output | 1 | Highway yellow lamp |
| hwy_red_o | output | 1 | Highway red lamp |
| farm_grn_o | output | 1 | Farm-road green lamp |
| farm_yel_o | output | 1 | Farm-road yellow lamp |
| farm_red_o | output | 1 | Farm-road red lamp |
| tmr_start_o | output | 1 | Timer restart strobe, one cycle per transition |

## Verification
The hardest case to reach is a race at the farm-green exit. The sensor must drop in the same cycle that the long flag becomes due, or just before it, and the two-flop delay shifts the sensor's effect by two cycles. The stimulus produces this with sensor bursts of varying length. It also uses a pattern that toggles every few cycles, which sweeps the point at which the sensor changes across the long boundary. A reset in the middle of farm green exercises re-initialisation from a state other than the idle one.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FARM_GO  = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_e;

  typedef struct packed {
    logic   hg;
    logic   hy;
    logic   hr;
    logic   fg;
    logic   fy;
    logic   fr;
    logic   strt;
    phase_e nxt;
  } ctrl_word_t;

  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned ROM_DEPTH = 1 << ADDR_W;

  // address: {init, car, short_done, long_done, phase[1:0]}
  function automatic ctrl_word_t rom_entry(logic [ADDR_W-1:0] a);
    ctrl_word_t w;
    logic   init, car, sd, ld, go;
    phase_e q;
    init = a[5];
    car  = a[4];
    sd   = a[3];
    ld   = a[2];
    q    = phase_e'(a[1:0]);
    w    = '0;
    go   = 1'b0;
    case (q)
      PH_HWY_GO:    begin w.hg = 1'b1; w.fr = 1'b1; go = ld & car;  end
      PH_HWY_WARN:  begin w.hy = 1'b1; w.fr = 1'b1; go = sd;        end
      PH_FARM_GO:   begin w.fg = 1'b1; w.hr = 1'b1; go = ld | ~car; end
      default:      begin w.fy = 1'b1; w.hr = 1'b1; go = sd;        end
    endcase
    if (init) begin
      w.strt = 1'b1;
      w.nxt  = PH_HWY_GO;
    end else if (go) begin
      w.strt = 1'b1;
      w.nxt  = phase_e'(a[1:0] + 2'd1);
    end else begin
      w.nxt  = q;
    end
    return w;
  endfunction

endpackage

// File: rtl/hfc_car_sync.sv
module hfc_car_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hfc_timer.sv
module hfc_timer #(
  parameter int unsigned SHORT_CNT = 3,
  parameter int unsigned LONG_CNT  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic short_done_o,
  output logic long_done_o
);
  localparam int unsigned CW = $clog2(LONG_CNT + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CNT);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q < LONG_V) cnt_q <= cnt_q + 1'b1;
  end

  assign short_done_o = (cnt_q >= SHORT_V);
  assign long_done_o  = (cnt_q >= LONG_V);

  a_r8_long_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_done_o && !restart_i) |=> long_done_o);
  a_r8_short_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_done_o && !restart_i) |=> short_done_o);
  a_r8_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_done_o |-> short_done_o);
  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!short_done_o && !long_done_o));
endmodule

// File: rtl/hfc_fsm.sv
module hfc_fsm
  import hfc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic car_s_i,
  input  logic short_done_i,
  input  logic long_done_i,
  output logic hwy_grn_o,
  output logic hwy_yel_o,
  output logic hwy_red_o,
  output logic farm_grn_o,
  output logic farm_yel_o,
  output logic farm_red_o,
  output logic tmr_start_o
);
  ctrl_word_t        rom [ROM_DEPTH];
  phase_e            phase_q;
  logic              init_q;
  logic [ADDR_W-1:0] addr;
  ctrl_word_t        word;

  generate
    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
      assign rom[g] = rom_entry(ADDR_W'(g));
    end
  endgenerate

  assign addr = {init_q, car_s_i, short_done_i, long_done_i, phase_q};
  assign word = rom[addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HWY_GO;
      init_q  <= 1'b1;
    end else begin
      phase_q <= word.nxt;
      init_q  <= 1'b0;
    end
  end

  assign hwy_grn_o   = word.hg;
  assign hwy_yel_o   = word.hy;
  assign hwy_red_o   = word.hr;
  assign farm_grn_o  = word.fg;
  assign farm_yel_o  = word.fy;
  assign farm_red_o  = word.fr;
  assign tmr_start_o = word.strt;

  a_r2_one_lamp_per_road: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({hwy_grn_o, hwy_yel_o, hwy_red_o}) == 1) &&
    ($countones({farm_grn_o, farm_yel_o, farm_red_o}) == 1));
  a_r2_never_both_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hwy_red_o || farm_red_o);
  a_r3_hold_highway: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HWY_GO && !(long_done_i && car_s_i)) |=> phase_q == PH_HWY_GO);
  a_r5_farm_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FARM_GO && !init_q && (long_done_i || !car_s_i)) |=> phase_q == PH_FARM_WARN);
  a_r7_quiet_means_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_start_o |=> $stable(phase_q));
endmodule

// File: rtl/hwy_farm_ctrl.sv
module hwy_farm_ctrl #(
  parameter int unsigned SHORT_CNT   = 3,
  parameter int unsigned LONG_CNT    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic car_i,
  output logic hwy_grn_o,
  output logic hwy_yel_o,
  output logic hwy_red_o,
  output logic farm_grn_o,
  output logic farm_yel_o,
  output logic farm_red_o,
  output logic tmr_start_o
);
  logic car_s, short_done, long_done, strobe;

  hfc_car_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (car_i),
    .sync_o  (car_s)
  );

  hfc_timer #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (strobe),
    .short_done_o (short_done),
    .long_done_o  (long_done)
  );

  hfc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .car_s_i      (car_s),
    .short_done_i (short_done),
    .long_done_i  (long_done),
    .hwy_grn_o    (hwy_grn_o),
    .hwy_yel_o    (hwy_yel_o),
    .hwy_red_o    (hwy_red_o),
    .farm_grn_o   (farm_grn_o),
    .farm_yel_o   (farm_yel_o),
    .farm_red_o   (farm_red_o),
    .tmr_start_o  (strobe)
  );

  assign tmr_start_o = strobe;
endmodule

// File: tb/hwy_farm_ctrl_tb.sv
`timescale 1ns/1ps
module hwy_farm_ctrl_tb;
  localparam int SH = 3;
  localparam int LG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic hg, hy, hr, fg, fy, fr, strt;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  hwy_farm_ctrl #(.SHORT_CNT(SH), .LONG_CNT(LG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .car_i(car),
    .hwy_grn_o(hg), .hwy_yel_o(hy), .hwy_red_o(hr),
    .farm_grn_o(fg), .farm_yel_o(fy), .farm_red_o(fr),
    .tmr_start_o(strt)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: phase 0..3, saturating count, 2-deep sensor queue
  int m_ph = 0;
  int m_cnt = 0;
  bit m_init = 1;
  bit m_q[$] = '{0, 0};

  function automatic bit m_go();
    bit c, ts, tl;
    c  = m_q[0];
    ts = (m_cnt >= SH);
    tl = (m_cnt >= LG);
    if (m_init) return 1;
    case (m_ph)
      0: return tl && c;
      1: return ts;
      2: return tl || !c;
      default: return ts;
    endcase
  endfunction

  function automatic logic [5:0] m_lamps();
    case (m_ph)
      0: return 6'b100_001;
      1: return 6'b010_001;
      2: return 6'b001_100;
      default: return 6'b001_010;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_init = 1; m_q = '{0, 0};
    end else begin
      bit go;
      go = m_go();
      if (go) begin
        m_ph  = m_init ? 0 : (m_ph + 1) % 4;
        m_cnt = 0;
      end else if (m_cnt < LG) begin
        m_cnt = m_cnt + 1;
      end
      m_init = 0;
      void'(m_q.pop_front());
      m_q.push_back(car);
    end
  end

  function automatic string tag_for();
    if (m_init) return "R1";
    case (m_ph)
      0: return "R3 R9";
      1: return "R4 R8";
      2: return "R5 R9";
      default: return "R6 R8";
    endcase
  endfunction

  always @(negedge clk) begin
    logic [5:0] act_l, exp_l;
    bit exp_s;
    cyc++;
    act_l = {hg, hy, hr, fg, fy, fr};
    exp_l = m_lamps();
    exp_s = m_go();
    n_cmp++;
    if (act_l !== exp_l) begin
      n_bad++;
      $display("FAIL R2 %s lamps cyc=%0d act=%b exp=%b", tag_for(), cyc, act_l, exp_l);
    end
    n_cmp++;
    if (strt !== exp_s) begin
      n_bad++;
      $display("FAIL R7 %s strobe cyc=%0d act=%b exp=%b", tag_for(), cyc, strt, exp_s);
    end
  end

  task automatic run(input bit c, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 car = c;
    end
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset held
    run(0, 3);
    @(posedge clk); #1 rst_n = 1'b1;
    run(0, 25);               // R3: no car, highway stays green
    run(1, 3);                // R3 R9: late car after long expiry, 2-flop delay
    run(1, 40);               // R5: farm green capped by long interval
    run(0, 20);
    run(1, 2);                // R3: car before long expiry must wait
    run(1, 12);
    run(0, 15);               // R5: farm empties early
    run(1, 1);                // single-cycle pulse
    run(0, 20);
    for (int k = 0; k < 120; k++) run(((k / 3) % 2) == 1, 1); // sweep sensor vs long boundary
    for (int k = 0; k < 80; k++)  run(((k / 7) % 2) == 0, 1);
    run(1, 14);
    // R1: reset while farm is green
    @(posedge clk); #1 rst_n = 1'b0;
    run(1, 3);
    @(posedge clk); #1 rst_n = 1'b1;
    run(1, 30);
    run(0, 30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule